// File: doc/BRIEF.md
# Interval Timer Count Latch and Read-Back Path

This block is the read side of a three-channel interval timer. It sits between a byte-wide CPU data bus and three counting elements. The counting and mode logic is outside the block. Each counting element supplies its live count, its output level, its null-count flag, its programmed mode, its BCD flag and its access format as plain inputs. The block does not decode addresses: the CPU side arrives as a command-write strobe with a data byte, and a read strobe with a channel index.

Each channel has three pieces of read state:
- an output latch that can freeze the live count;
- a status holding register that can freeze a status byte;
- a byte pointer that orders the two halves of a 16-bit value.

Two commands capture these values. A single-channel latch command freezes one count. A read-back command can freeze the counts, the status bytes, or both, for any set of channels at once.

CPU reads then return values in a fixed priority. A held status byte comes first. The held count comes next, in one or two bytes. After that, reads return the live count. Each hold releases by itself once it has been read out. A reprogram pulse from the mode logic drops both holds and resets the byte pointer.

Top module: `pit_readback`

## Requirements
- R1: With nothing held, a read returns the live count. In access format 2'b11 the first read gives the low byte and the next read gives the high byte, and this alternates. Format 2'b01 returns only the low byte. Format 2'b10 returns only the high byte.
- R2: A channel latch command freezes that channel's count on the clock edge that accepts it. The command is a data byte with D5:D4 = 00 and D7:D6 = channel number (0 to 2). Reads then return the frozen value while the live count moves on.
- R3: A held count releases once it has been fully read: after one read in a one-byte format, or after the high byte in format 2'b11. Later reads return the live count. A reprogram pulse releases both holds of that channel and resets its byte pointer to the low byte.
- R4: A read-back command freezes the counts of every channel it selects in one cycle. The command has D7:D6 = 11 and D5 = 0. Channels 0, 1 and 2 are selected by D1, D2 and D3 set to 1. Channels it does not select are not affected.
- R5: A read-back command with D4 = 0 freezes the status byte of each channel it selects. When a channel holds both a status byte and a count, its first read returns the status byte, whichever of the two was captured first. Reading the status byte does not consume the held count and does not move the byte pointer.
- R6: The status byte is laid out from bit 7 down to bit 0 as: OUT level (bit 7), null-count flag (bit 6), access format (bits 5:4), mode (bits 3:1), BCD flag (bit 0).
- R7: A latch request to a channel whose count is already held and unread has no effect on the held value.
- R8: A command byte with D7:D6 other than 11 and D5:D4 other than 00 is a mode-setting word, and it has no effect on this block.
- R9: A read with channel index 3 returns 0x00 and changes no channel's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_data_i | input | 8 | Command byte |
| rd_i | input | 1 | CPU read strobe; the read takes effect on the clock edge |
| rd_sel_i | input | 2 | Channel index of the read |
| rd_data_o | output | 8 | Read data for the channel selected by rd_sel_i |
| reprog_i | input | 3 | Per-channel pulse from the mode logic on reprogramming |
| cnt_i | input | 48 | Live counts, 16 bits per channel, channel 0 in the low bits |
| out_i | input | 3 | Per-channel OUT level |
| null_i | input | 3 | Per-channel null-count flag |
| mode_i | input | 9 | Per-channel mode, 3 bits each |
| bcd_i | input | 3 | Per-channel BCD flag |
| fmt_i | input | 6 | Per-channel access format, 2 bits each |

## Verification
The bound checker watches every cycle for the following:
- an accepted latch captures the live count of the previous cycle;
- a held count stays unchanged until it is read or the channel is reprogrammed;
- a repeated latch leaves a held count untouched;
- a status read leaves the count hold in place;
- a reprogram pulse clears both holds.

Only the bench scenarios can show the rest:
- the byte order across several reads;
- the point at which each hold releases in each access format;
- the exact bit positions of the status byte;
- the decoding of mixed command bytes.

// File: rtl/pit_rb_pkg.sv
package pit_rb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LSB  = 2'b01,
    FMT_MSB  = 2'b10,
    FMT_WORD = 2'b11
  } acc_fmt_e;

  function automatic logic is_readback(input logic [7:0] d);
    return d[7:6] == 2'b11;
  endfunction

  function automatic logic is_chan_latch(input logic [7:0] d);
    return (d[7:6] != 2'b11) && (d[5:4] == 2'b00);
  endfunction
endpackage

// File: rtl/pit_rb_decode.sv
module pit_rb_decode #(
  parameter int NUM_CNT = 3
) (
  input  logic               we_i,
  input  logic [7:0]         data_i,
  output logic [NUM_CNT-1:0] latch_cnt_o,
  output logic [NUM_CNT-1:0] latch_st_o
);
  import pit_rb_pkg::*;

  always_comb begin
    latch_cnt_o = '0;
    latch_st_o  = '0;
    if (we_i) begin
      for (int k = 0; k < NUM_CNT; k++) begin
        if (is_readback(data_i)) begin
          // R4/R5: D1..D3 select channels, D5/D4 active-low count/status
          latch_cnt_o[k] = data_i[k+1] & ~data_i[5];
          latch_st_o[k]  = data_i[k+1] & ~data_i[4];
        end else if (is_chan_latch(data_i)) begin
          latch_cnt_o[k] = (int'(data_i[7:6]) == k);
        end
        // R8: mode-setting words fall through untouched
      end
    end
  end
endmodule

// File: rtl/pit_rb_slot.sv
module pit_rb_slot #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             out_i,
  input  logic             null_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  input  logic [1:0]       fmt_i,
  input  logic             latch_cnt_i,
  input  logic             latch_st_i,
  input  logic             reprog_i,
  input  logic             rd_i,
  output logic [7:0]       byte_o,
  output logic             cnt_held_o,
  output logic             st_held_o,
  output logic [CNT_W-1:0] ol_o
);
  import pit_rb_pkg::*;

  localparam int HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] ol_q;
  logic [7:0]       st_q;
  logic             cnt_held_q, st_held_q, hi_next_q;
  logic [CNT_W-1:0] src_w;
  logic [7:0]       lo_w, hi_w;
  logic             word_w, last_byte_w;

  assign word_w      = (acc_fmt_e'(fmt_i) == FMT_WORD);
  assign last_byte_w = !word_w || hi_next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ol_q       <= '0;
      st_q       <= '0;
      cnt_held_q <= 1'b0;
      st_held_q  <= 1'b0;
      hi_next_q  <= 1'b0;
    end else if (reprog_i) begin
      // R3: reprogramming drops both holds and restarts at the low byte
      cnt_held_q <= 1'b0;
      st_held_q  <= 1'b0;
      hi_next_q  <= 1'b0;
    end else begin
      if (rd_i) begin
        if (st_held_q) begin
          st_held_q <= 1'b0;           // R5: status goes first, count kept
        end else begin
          if (word_w) hi_next_q <= ~hi_next_q;
          if (cnt_held_q && last_byte_w) cnt_held_q <= 1'b0;
        end
      end
      if (latch_st_i && !st_held_q) begin
        st_q      <= {out_i, null_i, fmt_i, mode_i, bcd_i};  // R6
        st_held_q <= 1'b1;
      end
      if (latch_cnt_i && !cnt_held_q) begin  // R7: held value not overwritten
        ol_q       <= cnt_i;
        cnt_held_q <= 1'b1;
      end
    end
  end

  assign src_w = cnt_held_q ? ol_q : cnt_i;
  assign lo_w  = src_w[BYTE_W-1:0];
  assign hi_w  = {{(BYTE_W-HI_W){1'b0}}, src_w[CNT_W-1:BYTE_W]};

  always_comb begin
    if (st_held_q)                             byte_o = st_q;
    else if (acc_fmt_e'(fmt_i) == FMT_MSB)     byte_o = hi_w;
    else if (word_w && hi_next_q)              byte_o = hi_w;
    else                                       byte_o = lo_w;
  end

  assign cnt_held_o = cnt_held_q;
  assign st_held_o  = st_held_q;
  assign ol_o       = ol_q;
endmodule

// File: rtl/pit_readback.sv
module pit_readback #(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_we_i,
  input  logic [7:0]               cmd_data_i,
  input  logic                     rd_i,
  input  logic [1:0]               rd_sel_i,
  output logic [7:0]               rd_data_o,
  input  logic [NUM_CNT-1:0]       reprog_i,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_i,
  input  logic [NUM_CNT-1:0]       out_i,
  input  logic [NUM_CNT-1:0]       null_i,
  input  logic [NUM_CNT*3-1:0]     mode_i,
  input  logic [NUM_CNT-1:0]       bcd_i,
  input  logic [NUM_CNT*2-1:0]     fmt_i
);
  logic [NUM_CNT-1:0]            latch_cnt_w, latch_st_w, rd_hit_w;
  logic [NUM_CNT-1:0]            cnt_held_w, st_held_w;
  logic [NUM_CNT-1:0][7:0]       byte_w;
  logic [NUM_CNT-1:0][CNT_W-1:0] ol_w;

  pit_rb_decode #(.NUM_CNT(NUM_CNT)) u_dec (
    .we_i       (cmd_we_i),
    .data_i     (cmd_data_i),
    .latch_cnt_o(latch_cnt_w),
    .latch_st_o (latch_st_w)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
    assign rd_hit_w[k] = rd_i && (int'(rd_sel_i) == k);

    pit_rb_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt_i[k*CNT_W +: CNT_W]),
      .out_i      (out_i[k]),
      .null_i     (null_i[k]),
      .mode_i     (mode_i[k*3 +: 3]),
      .bcd_i      (bcd_i[k]),
      .fmt_i      (fmt_i[k*2 +: 2]),
      .latch_cnt_i(latch_cnt_w[k]),
      .latch_st_i (latch_st_w[k]),
      .reprog_i   (reprog_i[k]),
      .rd_i       (rd_hit_w[k]),
      .byte_o     (byte_w[k]),
      .cnt_held_o (cnt_held_w[k]),
      .st_held_o  (st_held_w[k]),
      .ol_o       (ol_w[k])
    );
  end

  // R9: an index past the last channel reads as zero
  always_comb begin
    rd_data_o = 8'h00;
    for (int k = 0; k < NUM_CNT; k++)
      if (int'(rd_sel_i) == k) rd_data_o = byte_w[k];
  end
endmodule

// File: rtl/pit_readback_chk.sv
module pit_readback_chk #(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          rd_i,
  input logic [1:0]                    rd_sel_i,
  input logic [NUM_CNT-1:0]            reprog_i,
  input logic [NUM_CNT*CNT_W-1:0]      cnt_i,
  input logic [NUM_CNT-1:0]            latch_cnt_w,
  input logic [NUM_CNT-1:0]            cnt_held_w,
  input logic [NUM_CNT-1:0]            st_held_w,
  input logic [NUM_CNT-1:0][CNT_W-1:0] ol_w
);
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
    logic hit;
    assign hit = rd_i && (int'(rd_sel_i) == k);

    assert_latch_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latch_cnt_w[k] && !cnt_held_w[k] && !reprog_i[k]
      |=> cnt_held_w[k] && ol_w[k] == $past(cnt_i[k*CNT_W +: CNT_W]));

    assert_hold_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_held_w[k] && !hit && !reprog_i[k] |=> cnt_held_w[k] && $stable(ol_w[k]));

    assert_second_latch_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_held_w[k] && latch_cnt_w[k] && !reprog_i[k] |=> $stable(ol_w[k]));

    assert_status_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && st_held_w[k] && !reprog_i[k] |=> !st_held_w[k] && cnt_held_w[k] == $past(cnt_held_w[k]));

    assert_reprog_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reprog_i[k] |=> !cnt_held_w[k] && !st_held_w[k]);
  end
endmodule

bind pit_readback pit_readback_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .rd_sel_i   (rd_sel_i),
  .reprog_i   (reprog_i),
  .cnt_i      (cnt_i),
  .latch_cnt_w(latch_cnt_w),
  .cnt_held_w (cnt_held_w),
  .st_held_w  (st_held_w),
  .ol_w       (ol_w)
);

// File: tb/pit_readback_tb.sv
`timescale 1ns/1ps
module pit_readback_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_we = 1'b0, rd = 1'b0;
  logic [7:0]  cmd_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic [2:0]  reprog = '0;
  logic [15:0] c0 = 16'h1234, c1 = 16'h00A1, c2 = 16'hB200;
  // ch0: OUT=1 null=0 fmt=11 mode=011 bcd=0 ; ch1: OUT=0 null=1 fmt=01 mode=101 bcd=1
  // ch2: OUT=1 null=1 fmt=10 mode=000 bcd=0
  logic [2:0]  out_v  = 3'b101, null_v = 3'b110, bcd_v = 3'b010;
  logic [8:0]  mode_v = {3'b000, 3'b101, 3'b011};
  logic [5:0]  fmt_v  = {2'b10, 2'b01, 2'b11};

  int applied = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  int         req_q[$];

  always #10 clk = ~clk;

  pit_readback u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_data_i(cmd_data),
    .rd_i(rd), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .reprog_i(reprog),
    .cnt_i({c2, c1, c0}), .out_i(out_v), .null_i(null_v), .mode_i(mode_v),
    .bcd_i(bcd_v), .fmt_i(fmt_v)
  );

  task automatic cmd(input logic [7:0] d);
    cmd_we = 1'b1; cmd_data = d;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic rdx(input logic [1:0] sel, input logic [7:0] e, input int req);
    exp_q.push_back(e); req_q.push_back(req);
    rd = 1'b1; rd_sel = sel;
    @(negedge clk); rd = 1'b0;
  endtask

  // monitor: sample 1 ns before the rising edge that consumes the read
  always begin
    @(negedge clk); #9;
    if (rd) begin
      logic [7:0] e; int r;
      applied++;
      if (exp_q.size() == 0) begin
        errors++; $display("FAIL R%0d unexpected read: got %02h expected none", 0, rd_data);
      end else begin
        e = exp_q.pop_front(); r = req_q.pop_front();
        if (rd_data !== e) begin
          errors++; $display("FAIL R%0d sel %0d: got %02h expected %02h", r, rd_sel, rd_data, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, live reads in each format
    rdx(0, 8'h34, 1); rdx(0, 8'h12, 1);
    rdx(1, 8'hA1, 1); rdx(2, 8'hB2, 1);
    // R2: channel latch freezes count
    cmd(8'h00); c0 = 16'hABCD;
    rdx(0, 8'h34, 2); rdx(0, 8'h12, 2);
    // R3: released after high byte
    rdx(0, 8'hCD, 3); rdx(0, 8'hAB, 3);
    // R7: second latch ignored
    cmd(8'h00); c0 = 16'h5555; cmd(8'h00); c0 = 16'h6666;
    rdx(0, 8'hCD, 7); rdx(0, 8'hAB, 7);
    // R8: mode-setting word has no effect
    cmd(8'h34); c0 = 16'h7788;
    rdx(0, 8'h88, 8); rdx(0, 8'h77, 8);
    // R4: read-back counts of ch1 and ch2 only
    cmd(8'hDC); c1 = 16'h00F1; c2 = 16'hC300;
    rdx(1, 8'hA1, 4); rdx(1, 8'hF1, 4);
    rdx(2, 8'hB2, 4); rdx(2, 8'hC3, 4);
    rdx(0, 8'h88, 4); rdx(0, 8'h77, 4);
    // R5: count latched before status, status still read first
    cmd(8'h00); cmd(8'hE2); c0 = 16'h0102;
    rdx(0, 8'hB6, 5); rdx(0, 8'h88, 5); rdx(0, 8'h77, 5);
    rdx(0, 8'h02, 5); rdx(0, 8'h01, 5);
    // R6: status layout on ch1 (count+status) and ch2 (status only)
    cmd(8'hC4); c1 = 16'h00E5;
    rdx(1, 8'h5B, 6); rdx(1, 8'hF1, 6); rdx(1, 8'hE5, 6);
    cmd(8'hE8);
    rdx(2, 8'hE0, 6); rdx(2, 8'hC3, 6);
    // R3: reprogram releases both holds
    cmd(8'h80); cmd(8'hE8); c2 = 16'hD400;
    reprog = 3'b100; @(negedge clk); reprog = '0;
    rdx(2, 8'hD4, 3);
    // R9: index 3 reads zero and leaves ch0 hold intact
    cmd(8'h00); c0 = 16'h0A0B;
    rdx(3, 8'h00, 9);
    rdx(0, 8'h02, 9); rdx(0, 8'h01, 9);
    rdx(0, 8'h0B, 9); rdx(0, 8'h0A, 9);
    repeat (3) @(negedge clk);
    applied++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL R1 pending reads: got %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule